// File: doc/BRIEF.md
# Fractional Master Clock Divider

This block derives an audio master clock rate from a faster source clock. It does not divide by an integer. It advances a phase accumulator by a programmable step every source cycle. When the accumulator passes a programmable modulus, it subtracts the modulus and fires a one-cycle tick. Both numbers are written minus one, as a step field and a modulus field. The tick rate is therefore the source rate times (step+1)/(modulus+1). A companion square-wave output toggles on every tick and runs at half that rate. A clock-gating or enable stage further down the chip uses the tick to form the master clock edges.

Software writes a new ratio through a single-cycle write strobe. The block holds that ratio as pending and raises a busy flag. While the output is running, the pending ratio is taken into use at the next accumulator wrap, so the change never truncates a period. While the output is disabled, the pending ratio is taken into use on the next cycle. Software polls the busy flag until it clears. A ratio whose step exceeds its modulus would ask for an output faster than the source, so such a write is dropped.

Top module: `mclk_frac_div`

## Requirements
- R1: With the output enabled and the accumulator starting from zero, every window of N source cycles, where N is a multiple of modulus+1, contains exactly N·(step+1)/(modulus+1) ticks.
- R2: In a cycle where the accumulator plus step+1 reaches modulus+1 or more, the block subtracts modulus+1, and the tick is high in the following cycle. With step field 2 and modulus field 4, the ticks seen after enabling repeat as 0,1,0,1,1.
- R3: Both fields are stored minus one. Field value 0 means a factor of 1, so step 0 with modulus 0 ticks on every cycle. The step field is 8 bits wide.
- R4: After reset or a disable, the square-wave output starts low. It toggles on the same clock edge on which each tick is raised.
- R5: A valid write made while the output is enabled raises busy on the next cycle. Busy stays high until the next accumulator wrap. On that wrap the new ratio replaces the old one, the accumulator restarts from zero, and busy falls on the same edge as that wrap's tick.
- R6: A write whose step field is greater than its modulus field is discarded. Busy does not rise, and the running ratio is unchanged.
- R7: While the output enable is low, the tick and square-wave outputs stay low and the accumulator is held at zero. A write made while disabled shows busy high for exactly one cycle and then takes effect.
- R8: After reset, busy, tick and the square-wave output are low, and the ratio is step 0 over modulus 1.
- R9: A second valid write made while an earlier one is still pending replaces it. Only the latest ratio is taken into use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enable; low holds the divider idle |
| cfg_wr | input | 1 | One-cycle write strobe for a new ratio |
| cfg_step | input | FRACT_W | Step field, multiplier minus one |
| cfg_mod | input | DIV_W | Modulus field, divisor minus one |
| upd_busy | output | 1 | High while a written ratio is pending |
| mclk_tick | output | 1 | One-cycle pulse at the divided rate |
| mclk_out | output | 1 | Square wave toggling on each tick |

## Verification
A corrupted accumulator residue shows up at once in the tick pattern. Within one modulus period, the tick count in a window differs from step+1 per modulus+1 cycles. A pending-ratio or busy fault shows up within one old period after a write. Either busy fails to fall on a tick edge, or the tick spacing after it does not match the new ratio. A wrong enable path shows up on the first disabled cycle, as a stray tick, a high square wave, or a busy pulse longer than one cycle.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  // Update tracker for the ratio register pair
  typedef enum logic {
    UPD_IDLE = 1'b0,
    UPD_WAIT = 1'b1
  } upd_state_e;
endpackage

// File: rtl/mclk_ratio_regs.sv
module mclk_ratio_regs
  import mclk_div_pkg::*;
#(
  parameter int unsigned FRACT_W = 8,
  parameter int unsigned DIV_W   = 8,
  parameter logic [FRACT_W-1:0] RST_STEP = '0,
  parameter logic [DIV_W-1:0]   RST_MOD  = DIV_W'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr,
  input  logic [FRACT_W-1:0] wr_step,
  input  logic [DIV_W-1:0]   wr_mod,
  input  logic               wrap,
  output logic [FRACT_W-1:0] act_step,
  output logic [DIV_W-1:0]   act_mod,
  output logic               busy,
  output logic               load
);

  upd_state_e         state_q, state_d;
  logic [FRACT_W-1:0] pend_step_q, pend_step_d;
  logic [DIV_W-1:0]   pend_mod_q, pend_mod_d;
  logic [FRACT_W-1:0] act_step_d;
  logic [DIV_W-1:0]   act_mod_d;
  logic [DIV_W-1:0]   step_ext;
  logic               wr_ok;

  assign step_ext = DIV_W'(wr_step);
  assign wr_ok    = wr && (step_ext <= wr_mod);
  // pending ratio lands at a wrap, or at once when the output is idle
  assign load     = (state_q == UPD_WAIT) && (wrap || !en);

  always_comb begin
    state_d     = state_q;
    pend_step_d = pend_step_q;
    pend_mod_d  = pend_mod_q;
    act_step_d  = act_step_q_w();
    act_mod_d   = act_mod;
    if (load) begin
      act_step_d = pend_step_q;
      act_mod_d  = pend_mod_q;
      state_d    = UPD_IDLE;
    end
    if (wr_ok) begin
      pend_step_d = wr_step;
      pend_mod_d  = wr_mod;
      state_d     = UPD_WAIT;
    end
  end

  function automatic logic [FRACT_W-1:0] act_step_q_w();
    return act_step;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= UPD_IDLE;
      pend_step_q <= RST_STEP;
      pend_mod_q  <= RST_MOD;
      act_step    <= RST_STEP;
      act_mod     <= RST_MOD;
    end else begin
      state_q     <= state_d;
      pend_step_q <= pend_step_d;
      pend_mod_q  <= pend_mod_d;
      act_step    <= act_step_d;
      act_mod     <= act_mod_d;
    end
  end

  assign busy = (state_q == UPD_WAIT);

  assert_busy_falls_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wrap || !en));
  assert_reject_bad_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (DIV_W'(wr_step) > wr_mod) && !busy) |=> !busy);
  assert_active_ratio_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    DIV_W'(act_step) <= act_mod);
  assert_ratio_stable_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(act_mod));

endmodule

// File: rtl/mclk_phase_acc.sv
module mclk_phase_acc #(
  parameter int unsigned FRACT_W = 8,
  parameter int unsigned DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               load,
  input  logic [FRACT_W-1:0] step,
  input  logic [DIV_W-1:0]   modv,
  output logic               wrap,
  output logic               tick
);

  localparam int unsigned ACC_W = DIV_W + 1;

  logic [DIV_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum, limit, diff;
  logic             tick_d;

  assign sum   = ACC_W'(acc_q) + ACC_W'(step) + ACC_W'(1);
  assign limit = ACC_W'(modv) + ACC_W'(1);
  assign diff  = sum - limit;
  assign wrap  = en && (sum >= limit);

  always_comb begin
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (!en) begin
      acc_d = '0;
    end else begin
      tick_d = wrap;
      if (load)      acc_d = '0;
      else if (wrap) acc_d = diff[DIV_W-1:0];
      else           acc_d = sum[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tick  <= tick_d;
    end
  end

  assert_acc_below_modulus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= modv);
  assert_no_tick_while_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);
  assert_acc_zero_while_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_q == '0));

endmodule

// File: rtl/mclk_edge_gen.sv
module mclk_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wrap,
  output logic mclk
);

  logic mclk_d;

  always_comb begin
    if (!en)       mclk_d = 1'b0;
    else if (wrap) mclk_d = ~mclk;
    else           mclk_d = mclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclk <= 1'b0;
    else        mclk <= mclk_d;
  end

  assert_toggle_only_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk != $past(mclk)) |-> ($past(wrap) || !$past(en)));
  assert_low_while_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mclk);

endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div #(
  parameter int unsigned FRACT_W = 8,
  parameter int unsigned DIV_W   = 8
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               out_en,
  input  logic               cfg_wr,
  input  logic [FRACT_W-1:0] cfg_step,
  input  logic [DIV_W-1:0]   cfg_mod,
  output logic               upd_busy,
  output logic               mclk_tick,
  output logic               mclk_out
);

  logic [FRACT_W-1:0] act_step;
  logic [DIV_W-1:0]   act_mod;
  logic               load;
  logic               wrap;

  mclk_ratio_regs #(
    .FRACT_W (FRACT_W),
    .DIV_W   (DIV_W),
    .RST_STEP('0),
    .RST_MOD (DIV_W'(1))
  ) u_regs (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .en      (out_en),
    .wr      (cfg_wr),
    .wr_step (cfg_step),
    .wr_mod  (cfg_mod),
    .wrap    (wrap),
    .act_step(act_step),
    .act_mod (act_mod),
    .busy    (upd_busy),
    .load    (load)
  );

  mclk_phase_acc #(
    .FRACT_W(FRACT_W),
    .DIV_W  (DIV_W)
  ) u_acc (
    .clk  (clk_src),
    .rst_n(rst_n),
    .en   (out_en),
    .load (load),
    .step (act_step),
    .modv (act_mod),
    .wrap (wrap),
    .tick (mclk_tick)
  );

  mclk_edge_gen u_edge (
    .clk  (clk_src),
    .rst_n(rst_n),
    .en   (out_en),
    .wrap (wrap),
    .mclk (mclk_out)
  );

  assert_tick_pairs_with_edge_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
    (out_en && $past(out_en) && mclk_tick) |-> (mclk_out != $past(mclk_out)));

endmodule

// File: tb/sim_mclk_frac_div.sv
`timescale 1ns/1ps
module sim_mclk_frac_div;

  localparam int unsigned FW = 8;
  localparam int unsigned DW = 8;

  logic          clk_src = 1'b0;
  logic          rst_n;
  logic          out_en;
  logic          cfg_wr;
  logic [FW-1:0] cfg_step;
  logic [DW-1:0] cfg_mod;
  logic          upd_busy, mclk_tick, mclk_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_src = ~clk_src;

  mclk_frac_div #(.FRACT_W(FW), .DIV_W(DW)) u0 (
    .clk_src, .rst_n, .out_en, .cfg_wr, .cfg_step, .cfg_mod,
    .upd_busy, .mclk_tick, .mclk_out
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ratio(input int s, input int m);
    @(negedge clk_src);
    cfg_wr = 1'b1; cfg_step = FW'(s); cfg_mod = DW'(m);
    @(negedge clk_src);
    cfg_wr = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_src);
      if (mclk_tick) cnt++;
    end
  endtask

  // R7 R1 R4: load while idle, then measure rate and square-wave parity
  task automatic t_rate(input int s, input int m, input string req);
    int cnt;
    int n;
    @(negedge clk_src); out_en = 1'b0;
    wr_ratio(s, m);
    chk(upd_busy == 1'b1, "R7", upd_busy, 1);
    @(negedge clk_src);
    chk(upd_busy == 1'b0, "R7", upd_busy, 0);
    chk(mclk_out == 1'b0, "R4", mclk_out, 0);
    out_en = 1'b1;
    n = 2 * (m + 1);
    count_ticks(n, cnt);
    chk(cnt == n * (s + 1) / (m + 1), req, cnt, n * (s + 1) / (m + 1));
    chk(mclk_out == cnt[0], "R4", mclk_out, cnt[0]);
  endtask

  // R2: exact tick spacing for 3 of every 5
  task automatic t_pattern;
    bit exp_bits [5] = '{0, 1, 0, 1, 1};
    @(negedge clk_src); out_en = 1'b0;
    wr_ratio(2, 4);
    @(negedge clk_src); out_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_src);
      chk(mclk_tick == exp_bits[i % 5], "R2", mclk_tick, exp_bits[i % 5]);
    end
  endtask

  // R7: nothing moves while disabled
  task automatic t_disabled;
    int seen = 0;
    @(negedge clk_src); out_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_src);
      if (mclk_tick || mclk_out) seen++;
    end
    chk(seen == 0, "R7", seen, 0);
  endtask

  // R6: step above modulus is dropped
  task automatic t_invalid;
    int cnt;
    t_rate(0, 3, "R1");
    wr_ratio(5, 2);
    chk(upd_busy == 1'b0, "R6", upd_busy, 0);
    count_ticks(16, cnt);
    chk(cnt == 4, "R6", cnt, 4);
  endtask

  // R5: change while running lands on a wrap
  task automatic t_live;
    int cnt;
    int wait_n = 0;
    t_rate(0, 3, "R1");
    wr_ratio(0, 1);
    chk(upd_busy == 1'b1, "R5", upd_busy, 1);
    while (upd_busy && wait_n < 8) begin
      @(negedge clk_src); wait_n++;
    end
    chk(wait_n <= 4, "R5", wait_n, 4);
    chk(mclk_tick == 1'b1, "R5", mclk_tick, 1);
    count_ticks(8, cnt);
    chk(cnt == 4, "R5", cnt, 4);
  endtask

  // R9: latest pending write wins
  task automatic t_overwrite;
    int cnt;
    int wait_n = 0;
    t_rate(0, 7, "R1");
    wr_ratio(0, 3);
    wr_ratio(1, 1);
    while (upd_busy && wait_n < 12) begin
      @(negedge clk_src); wait_n++;
    end
    chk(upd_busy == 1'b0, "R9", upd_busy, 0);
    count_ticks(8, cnt);
    chk(cnt == 8, "R9", cnt, 8);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; out_en = 1'b0; cfg_wr = 1'b0; cfg_step = '0; cfg_mod = '0;
    repeat (3) @(negedge clk_src);
    rst_n = 1'b1;
    @(negedge clk_src);
    // R8: reset state, then default ratio 1/2
    chk(upd_busy == 1'b0, "R8", upd_busy, 0);
    chk(mclk_tick == 1'b0, "R8", mclk_tick, 0);
    chk(mclk_out == 1'b0, "R8", mclk_out, 0);
    out_en = 1'b1;
    count_ticks(8, cnt);
    chk(cnt == 4, "R8", cnt, 4);
    t_rate(0, 0, "R3");
    t_rate(2, 4, "R1");
    t_rate(1, 6, "R1");
    t_rate(254, 255, "R1");
    t_rate(255, 255, "R3");
    t_pattern();
    t_disabled();
    t_invalid();
    t_live();
    t_overwrite();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule